// File: doc/BRIEF.md
# Serial debug link resync detector

This block watches the two lines of a serial wire debug link, the probe clock and the bidirectional data line, after both have been brought into the system clock domain. It looks for the two link-level sequences that force a target back to a known framing state. The first is a line reset, which is a long run of data-high bits sampled on probe clock rising edges. The second is the 16-bit select pattern that moves a target from a JTAG-style port to the two-wire protocol. It does not decode transactions and never drives the bus.

When either sequence is recognised, the block raises a resync pulse for one system cycle. A kind output tells which sequence was seen. A run-length output carries the number of high bits that made up a line reset. A transaction decoder placed beside it can use the pulse to drop whatever frame it was in the middle of.

A line reset is reported when the high run ends, on the first rising edge that samples the data line low. It is not reported when the count reaches the threshold. The select pattern is compared with the most recent 16 sampled bits, taking the first bit on the wire as bit 0.

Top module: `swd_resync_detect`

## Requirements
- R1: While and after synchronous reset, with no probe clock edge seen yet, `resync_pulse`, `resync_kind` and `run_len` are all 0.
- R2: Only rising edges of the probe clock sample the data line. System cycles without such an edge, including a data line held high while the probe clock stays still, change neither the high-run count nor the pattern history.
- R3: When a rising edge samples data 0 and at least `RESET_MIN` (default 50) data-1 edges came directly before it, the block gives one pulse with `resync_kind` = 0. `run_len` then holds the length of the run, so exactly 50 ones followed by a 0 gives `run_len` = 50.
- R4: A high run of `RESET_MIN`-1 edges (49) followed by a 0 gives no pulse.
- R5: The high-run count saturates at 2^`CNT_W`-1 (255) and does not wrap. A run of 300 ones followed by a 0 reports `run_len` = 255.
- R6: When the last 16 sampled bits equal 0xE79E, with the earliest of them as bit 0 (first on the wire 0,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1), the block gives one pulse with `resync_kind` = 1.
- R7: A pattern match clears both the pattern history and the high-run count. A match whose three trailing ones are followed by 47 ones and a 0 therefore gives no line reset.
- R8: `resync_pulse` lasts exactly one system cycle per event. `run_len` changes only together with a pulse.
- R9: No pulse is given while a high run is still going on, however long it gets.
- R10: A line reset erases the earlier pattern history. Its terminating 0 bit becomes the first bit of the new history, so 60 ones followed by the 16-bit pattern gives a line reset pulse and then a match pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_clk_in | input | 1 | Probe clock line, asynchronous to clk |
| probe_dio_in | input | 1 | Data line level, asynchronous to clk |
| resync_pulse | output | 1 | One-cycle pulse on a recognised sequence |
| resync_kind | output | 1 | 0 = line reset, 1 = select pattern; valid with the pulse |
| run_len | output | CNT_W | Saturated high-run length of the last line reset |

## Verification
The assertions assume that each probe clock phase lasts several system cycles, so every rising edge passes the synchroniser. They also assume the data line settles while the probe clock is low, so the sampled bit is stable at each edge. The bench only changes the data line in the low phase and holds each phase for six system cycles. Random bit streams are biased towards long high runs and have whole select patterns mixed in. Because of this, runs end on both sides of the threshold and matches occur right after line resets.

// File: rtl/swd_resync_pkg.sv
package swd_resync_pkg;
  typedef enum logic {
    EV_LINE_RESET = 1'b0,
    EV_SELECT     = 1'b1
  } resync_kind_e;

  localparam int DEF_RESET_MIN = 50;
  localparam int DEF_CNT_W     = 8;
  localparam int DEF_PAT_W     = 16;
  localparam logic [15:0] DEF_PATTERN = 16'hE79E;
endpackage

// File: rtl/swd_line_sync.sv
module swd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_raw,
  input  logic dio_raw,
  output logic rise,
  output logic dio_s
);
  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] dio_chain;
  logic              clk_last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            clk_chain[0] <= 1'b0;
            dio_chain[0] <= 1'b0;
          end else begin
            clk_chain[0] <= clk_raw;
            dio_chain[0] <= dio_raw;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            clk_chain[g] <= 1'b0;
            dio_chain[g] <= 1'b0;
          end else begin
            clk_chain[g] <= clk_chain[g-1];
            dio_chain[g] <= dio_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_last <= 1'b0;
    else     clk_last <= clk_chain[STAGES-1];
  end

  assign rise  = clk_chain[STAGES-1] & ~clk_last;
  assign dio_s = dio_chain[STAGES-1];
endmodule

// File: rtl/swd_run_counter.sv
module swd_run_counter #(
  parameter int RESET_MIN = 50,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             dio,
  input  logic             clear,
  output logic             reset_hit,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(RESET_MIN);

  assign reset_hit = step & ~dio & (cnt >= MIN_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      if (!dio || clear)      cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swd_pattern_match.sv
module swd_pattern_match #(
  parameter int             PAT_W   = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'hE79E
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic dio,
  input  logic flush,
  output logic hit
);
  localparam int FILL_W = $clog2(PAT_W + 1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(PAT_W);

  logic [PAT_W-1:0]  hist, hist_nx;
  logic [FILL_W-1:0] fill, fill_nx;

  always_comb begin
    if (flush) begin
      hist_nx = {dio, {(PAT_W-1){1'b0}}};
      fill_nx = FILL_W'(1);
    end else begin
      hist_nx = {dio, hist[PAT_W-1:1]};
      fill_nx = (fill == FULL) ? fill : fill + 1'b1;
    end
  end

  assign hit = step & ~flush & (fill_nx == FULL) & (hist_nx == PATTERN);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
    end else if (step) begin
      if (hit) begin
        hist <= '0;
        fill <= '0;
      end else begin
        hist <= hist_nx;
        fill <= fill_nx;
      end
    end
  end
endmodule

// File: rtl/swd_resync_detect.sv
module swd_resync_detect
  import swd_resync_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               RESET_MIN   = DEF_RESET_MIN,
  parameter int               CNT_W       = DEF_CNT_W,
  parameter int               PAT_W       = DEF_PAT_W,
  parameter logic [PAT_W-1:0] PATTERN     = DEF_PATTERN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             probe_clk_in,
  input  logic             probe_dio_in,
  output logic             resync_pulse,
  output logic             resync_kind,
  output logic [CNT_W-1:0] run_len
);
  logic             rise;
  logic             dio_s;
  logic             reset_hit;
  logic             pat_hit;
  logic [CNT_W-1:0] run_cnt;

  swd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clk_raw(probe_clk_in), .dio_raw(probe_dio_in),
    .rise(rise), .dio_s(dio_s)
  );

  swd_run_counter #(.RESET_MIN(RESET_MIN), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst(rst), .step(rise), .dio(dio_s), .clear(pat_hit),
    .reset_hit(reset_hit), .cnt(run_cnt)
  );

  swd_pattern_match #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_pat (
    .clk(clk), .rst(rst), .step(rise), .dio(dio_s), .flush(reset_hit),
    .hit(pat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resync_pulse <= 1'b0;
      resync_kind  <= EV_LINE_RESET;
      run_len      <= '0;
    end else begin
      resync_pulse <= reset_hit | pat_hit;
      if (reset_hit) begin
        resync_kind <= EV_LINE_RESET;
        run_len     <= run_cnt;
      end else if (pat_hit) begin
        resync_kind <= EV_SELECT;
      end
    end
  end
endmodule

// File: rtl/swd_resync_checker.sv
module swd_resync_checker #(
  parameter int RESET_MIN = 50,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             resync_pulse,
  input logic             resync_kind,
  input logic [CNT_W-1:0] run_len,
  input logic             rise,
  input logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(RESET_MIN);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resync_pulse |=> !resync_pulse); // R8
  AST_LEN_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    !resync_pulse |-> $stable(run_len)); // R8
  AST_PULSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    resync_pulse |-> $past(rise)); // R2
  AST_RESET_LEN_MIN: assert property (@(posedge clk) disable iff (rst)
    (resync_pulse && !resync_kind) |-> (run_len >= MIN_V)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == CNT_MAX) |=> (run_cnt == CNT_MAX || run_cnt == '0)); // R5
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(run_cnt)); // R2
endmodule

bind swd_resync_detect swd_resync_checker #(
  .RESET_MIN(RESET_MIN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .resync_pulse(resync_pulse), .resync_kind(resync_kind),
  .run_len(run_len), .rise(rise), .run_cnt(run_cnt)
);

// File: tb/sim_swd_resync_detect.sv
module sim_swd_resync_detect;
  localparam int CNT_W = 8;
  localparam logic [15:0] PAT = 16'hE79E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pclk = 1'b0;
  logic pdio = 1'b0;
  logic pulse;
  logic kind;
  logic [CNT_W-1:0] len;

  always #5 clk = ~clk;

  swd_resync_detect u0 (
    .clk(clk), .rst(rst), .probe_clk_in(pclk), .probe_dio_in(pdio),
    .resync_pulse(pulse), .resync_kind(kind), .run_len(len)
  );

  int checks = 0;
  int fails = 0;
  int seen = 0;
  logic seen_kind = 1'b0;
  int seen_len = 0;
  logic prev_pulse = 1'b0;
  int wide = 0;

  // reference model
  int m_cnt = 0;
  logic [15:0] m_hist = '0;
  int m_fill = 0;
  int m_pulses = 0;
  logic m_kind = 1'b0;
  int m_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (pulse) begin
        seen++;
        seen_kind = kind;
        seen_len = int'(len);
      end
      if (pulse && prev_pulse) wide++;
      prev_pulse = pulse;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_bit(input logic v);
    if (!v) begin
      if (m_cnt >= 50) begin
        m_pulses++; m_kind = 1'b0; m_len = m_cnt;
        m_hist = {v, 15'b0}; m_fill = 1; m_cnt = 0;
        return;
      end
      m_cnt = 0;
    end else if (m_cnt < 255) m_cnt++;
    m_hist = {v, m_hist[15:1]};
    if (m_fill < 16) m_fill++;
    if (m_fill == 16 && m_hist == PAT) begin
      m_pulses++; m_kind = 1'b1;
      m_hist = '0; m_fill = 0; m_cnt = 0;
    end
  endfunction

  task automatic send(input logic v);
    model_bit(v);
    pdio = v;
    pclk = 1'b0;
    repeat (6) @(posedge clk);
    pclk = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) send(1'b1);
  endtask

  task automatic send_pat();
    for (int i = 0; i < 16; i++) send(PAT[i]);
  endtask

  task automatic settle();
    pclk = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 pulse", int'(pulse), 0);
    chk("R1 kind", int'(kind), 0);
    chk("R1 len", int'(len), 0);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 len after release", int'(len), 0);

    // R4: 49 ones then a zero
    base = seen;
    ones(49); send(1'b0); settle();
    chk("R4 no pulse", seen - base, 0);

    // R9 and R3: exactly 50
    base = seen;
    ones(50); settle();
    chk("R9 no pulse during run", seen - base, 0);
    send(1'b0); settle();
    chk("R3 pulse count", seen - base, 1);
    chk("R3 kind", int'(seen_kind), 0);
    chk("R3 run length", seen_len, 50);

    // R2: idle probe clock with data high does not count
    base = seen;
    ones(45);
    pdio = 1'b1; pclk = 1'b0;
    repeat (300) @(posedge clk);
    send(1'b0); settle();
    chk("R2 idle cycles not counted", seen - base, 0);

    // R5: saturation
    base = seen;
    ones(300); send(1'b0); settle();
    chk("R5 pulse count", seen - base, 1);
    chk("R5 saturated length", seen_len, 255);

    // R6: select pattern after zeros
    base = seen;
    send(1'b0); send(1'b0); send_pat(); settle();
    chk("R6 pulse count", seen - base, 1);
    chk("R6 kind", int'(seen_kind), 1);
    chk("R8 length unchanged by match", seen_len, 255);

    // R7: match clears run count
    base = seen;
    send(1'b0); send_pat(); ones(47); send(1'b0); settle();
    chk("R7 one pulse only", seen - base, 1);
    chk("R7 kind", int'(seen_kind), 1);

    // R10: line reset then pattern starting with the terminating zero
    base = seen;
    ones(60); send_pat(); settle();
    chk("R10 pulse count", seen - base, 2);
    chk("R10 last kind", int'(seen_kind), 1);
    chk("R10 reset length", m_len, 60);

    // random streams against the model
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 40; c++) begin
      int r = $urandom_range(0, 3);
      if (r == 0) send_pat();
      else if (r == 1) begin
        ones($urandom_range(44, 56)); send(1'b0);
      end else begin
        for (int k = 0; k < 12; k++) send(1'($urandom_range(0, 5) != 0));
      end
      settle();
      chk("R3 R6 random pulse total", seen, m_pulses);
      if (m_pulses > 0) begin
        chk("R6 random kind", int'(seen_kind), int'(m_kind));
        chk("R3 random length", seen_len, m_len);
      end
    end

    chk("R8 single-cycle pulses", wide, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule